// File: doc/BRIEF.md
# Burst Write Strobe Generator

This block walks a write burst one beat at a time and, for every beat, produces that beat's byte address, the byte-lane write strobe mask for a 32-bit (four-lane) data bus and a flag marking the final beat. A command gives the start address, the transfer size, the beat count minus one and the burst kind. The command is taken on a valid/ready handshake. Beats are then offered on a second valid/ready handshake until the final beat has been taken.

Each beat's mask is worked out again from that beat's own address. Narrow bursts therefore move across the lanes as the address advances. An unaligned start yields a clipped first beat. Fixed bursts repeat one pattern, and wrapping bursts follow the folded addresses inside their window. The mask always covers the whole addressed lane span; there is no sparse sub-masking. A downstream write path would merge these strobes with its data beats.

Top module: `strb_burst_gen`

## Requirements
- R1: After reset, and until the first command is accepted, `cmd_ready` is 1 and `beat_valid` is 0.
- R2: For each offered beat, with lane offset o = `beat_addr` mod 4 and n = 2^min(size,2) bytes, `beat_strb[k]` is 1 exactly when o <= k < (o rounded down to a multiple of n) + n. Size codes above 2 act as size 2.
- R3: A command is accepted in a cycle where `cmd_valid` and `cmd_ready` are both 1. From the next cycle `beat_valid` is 1, `beat_addr` equals the command address, and `cmd_ready` stays 0 while the burst is active.
- R4: In an incrementing burst (`cmd_burst` = 1), each beat address after the first is the previous address rounded down to a multiple of n, plus n.
- R5: In a fixed burst (`cmd_burst` = 0), every beat carries the start address and the same strobe mask.
- R6: In a wrapping burst (`cmd_burst` = 2, aligned start, 2/4/8/16 beats), the window is W = (len+1)*n bytes starting at the start address rounded down to a multiple of W. Each next address is the window base plus ((aligned previous address + n - base) mod W).
- R7: While `beat_valid` is 1 and `beat_ready` is 0, the beat's address, strobe and last flag hold unchanged.
- R8: Exactly len+1 beats are offered. `beat_last` is 1 only on the beat numbered len. In the cycle after that beat's handshake, `beat_valid` is 0 and `cmd_ready` is 1.
- R9: The reserved burst code 3 behaves as an incrementing burst.
- R10: A command presented while a burst is active is not accepted and does not change the beats in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Generator idle, command can be taken |
| cmd_addr | input | 32 | Burst start byte address |
| cmd_size | input | 3 | Bytes per beat as log2 |
| cmd_len | input | 8 | Beat count minus one |
| cmd_burst | input | 2 | 0 fixed, 1 incrementing, 2 wrapping, 3 treated as incrementing |
| beat_valid | output | 1 | A beat is offered |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_addr | output | 32 | Byte address of the offered beat |
| beat_strb | output | 4 | Byte-lane strobes of the offered beat |
| beat_last | output | 1 | Offered beat is the final one |

## Verification
Some properties are checked by assertions on every cycle:
- the lowest strobe bit sits at the beat's own lane offset and never more than 2^size lanes are set;
- beats hold while stalled;
- incrementing beats after the first are size-aligned;
- fixed beats repeat exactly;
- wrapping beats never leave their window;
- the last handshake always returns the block to idle.

Only the bench's scenarios can show the exact rotating and clipped strobe sequences, the fold point of each wrap, the clamping of large sizes, the reserved burst code, and the fact that commands offered during a burst are ignored. It compares every cycle against a beat list computed in advance, under both continuous and stalled consumption.

// File: rtl/strb_pkg.sv
package strb_pkg;

    typedef enum logic [1:0] {
        BK_FIXED = 2'd0,
        BK_INCR  = 2'd1,
        BK_WRAP  = 2'd2,
        BK_RSVD  = 2'd3
    } burst_kind_e;

endpackage

// File: rtl/strb_cmd_decode.sv
module strb_cmd_decode
    import strb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 4,
    parameter int LEN_W     = 8,
    localparam int OFS_W    = $clog2(BUS_BYTES),
    localparam int SZ_W     = $clog2(OFS_W + 1)
) (
    input  logic [2:0]        size_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [1:0]        burst_i,
    output logic [SZ_W-1:0]   size_eff_o,
    output logic [ADDR_W-1:0] lane_mask_o,
    output logic [ADDR_W-1:0] wrap_mask_o,
    output burst_kind_e       kind_o
);
    logic [ADDR_W-1:0] beats_ext;
    logic [ADDR_W-1:0] wrap_bytes;

    always_comb begin
        // sizes wider than the bus are clamped to the bus width
        if (int'(size_i) > OFS_W) begin
            size_eff_o = SZ_W'(OFS_W);
        end else begin
            size_eff_o = SZ_W'(size_i);
        end
        lane_mask_o = (ADDR_W'(1) << size_eff_o) - ADDR_W'(1);
        beats_ext   = ADDR_W'(len_i) + ADDR_W'(1);
        wrap_bytes  = beats_ext << size_eff_o;
        wrap_mask_o = wrap_bytes - ADDR_W'(1);
        case (burst_i)
            2'd0:    kind_o = BK_FIXED;
            2'd2:    kind_o = BK_WRAP;
            default: kind_o = BK_INCR;
        endcase
    end
endmodule

// File: rtl/strb_lane_mask.sv
module strb_lane_mask #(
    parameter int BUS_BYTES = 4,
    localparam int OFS_W    = $clog2(BUS_BYTES),
    localparam int SZ_W     = $clog2(OFS_W + 1)
) (
    input  logic [OFS_W-1:0]     ofs_i,
    input  logic [SZ_W-1:0]      size_i,
    output logic [BUS_BYTES-1:0] strb_o
);
    logic [OFS_W:0] nbytes;
    logic [OFS_W:0] first;
    logic [OFS_W:0] span_base;
    logic [OFS_W:0] span_end;

    always_comb begin
        nbytes    = (OFS_W+1)'(1) << size_i;
        first     = {1'b0, ofs_i};
        span_base = first & ~(nbytes - (OFS_W+1)'(1));
        span_end  = span_base + nbytes;
    end

    for (genvar gl = 0; gl < BUS_BYTES; gl++) begin : g_lane
        assign strb_o[gl] = ((OFS_W+1)'(gl) >= first) && ((OFS_W+1)'(gl) < span_end);
    end
endmodule

// File: rtl/strb_next_addr.sv
module strb_next_addr
    import strb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] lane_mask_i,
    input  logic [ADDR_W-1:0] wrap_mask_i,
    input  burst_kind_e       kind_i,
    output logic [ADDR_W-1:0] next_o
);
    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] stepped;

    always_comb begin
        aligned = addr_i & ~lane_mask_i;
        stepped = aligned + lane_mask_i + ADDR_W'(1);
        case (kind_i)
            BK_FIXED: next_o = addr_i;
            BK_WRAP:  next_o = (addr_i & ~wrap_mask_i) | (stepped & wrap_mask_i);
            default:  next_o = stepped;
        endcase
    end
endmodule

// File: rtl/strb_burst_gen.sv
module strb_burst_gen
    import strb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 4,
    parameter int LEN_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [2:0]           cmd_size,
    input  logic [LEN_W-1:0]     cmd_len,
    input  logic [1:0]           cmd_burst,
    output logic                 beat_valid,
    input  logic                 beat_ready,
    output logic [ADDR_W-1:0]    beat_addr,
    output logic [BUS_BYTES-1:0] beat_strb,
    output logic                 beat_last
);
    localparam int OFS_W = $clog2(BUS_BYTES);
    localparam int SZ_W  = $clog2(OFS_W + 1);

    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] addr;
        logic [SZ_W-1:0]   size;
        logic [ADDR_W-1:0] lmask;
        logic [ADDR_W-1:0] wmask;
        burst_kind_e       kind;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic [SZ_W-1:0]   dec_size;
    logic [ADDR_W-1:0] dec_lmask;
    logic [ADDR_W-1:0] dec_wmask;
    burst_kind_e       dec_kind;
    logic [ADDR_W-1:0] addr_next;
    logic              at_last;

    strb_cmd_decode #(
        .ADDR_W   (ADDR_W),
        .BUS_BYTES(BUS_BYTES),
        .LEN_W    (LEN_W)
    ) u_decode (
        .size_i     (cmd_size),
        .len_i      (cmd_len),
        .burst_i    (cmd_burst),
        .size_eff_o (dec_size),
        .lane_mask_o(dec_lmask),
        .wrap_mask_o(dec_wmask),
        .kind_o     (dec_kind)
    );

    strb_next_addr #(
        .ADDR_W(ADDR_W)
    ) u_step (
        .addr_i     (st_q.addr),
        .lane_mask_i(st_q.lmask),
        .wrap_mask_i(st_q.wmask),
        .kind_i     (st_q.kind),
        .next_o     (addr_next)
    );

    strb_lane_mask #(
        .BUS_BYTES(BUS_BYTES)
    ) u_lanes (
        .ofs_i (st_q.addr[OFS_W-1:0]),
        .size_i(st_q.size),
        .strb_o(beat_strb)
    );

    assign at_last = (st_q.cnt == st_q.len);

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (cmd_valid) begin
                st_d.busy  = 1'b1;
                st_d.addr  = cmd_addr;
                st_d.size  = dec_size;
                st_d.lmask = dec_lmask;
                st_d.wmask = dec_wmask;
                st_d.kind  = dec_kind;
                st_d.len   = cmd_len;
                st_d.cnt   = '0;
            end
        end else if (beat_ready) begin
            if (at_last) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt  = st_q.cnt + LEN_W'(1);
                st_d.addr = addr_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ready  = !st_q.busy;
    assign beat_valid = st_q.busy;
    assign beat_addr  = st_q.addr;
    assign beat_last  = st_q.busy && at_last;

    // R3: accepted command shows up as the first beat
    a_r3_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> beat_valid && (beat_addr == $past(cmd_addr)));

    // R2: lowest strobe lies on the beat's own lane, span never exceeds the size
    a_r2_strb_span: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> beat_strb[beat_addr[OFS_W-1:0]]
                       && ($countones(beat_strb) <= (1 << st_q.size)));

    // R7: stalled beat holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr)
                                      && $stable(beat_strb) && $stable(beat_last));

    // R8: final handshake returns to idle
    a_r8_last_idle: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && beat_last |=> !beat_valid && cmd_ready);

    // R4: incrementing beats after the first are size-aligned
    a_r4_incr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && !beat_last && (st_q.kind == BK_INCR)
        |=> (beat_addr & st_q.lmask) == '0);

    // R5: fixed bursts repeat the beat exactly
    a_r5_fixed_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && !beat_last && (st_q.kind == BK_FIXED)
        |=> (beat_addr == $past(beat_addr)) && (beat_strb == $past(beat_strb)));

    // R6: wrapping bursts stay in their window
    a_r6_wrap_window: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ready && !beat_last && (st_q.kind == BK_WRAP)
        |=> ((beat_addr ^ $past(beat_addr)) & ~st_q.wmask) == '0);

endmodule

// File: tb/strb_burst_gen_bench.sv
module strb_burst_gen_bench;

    localparam int NCMD  = 15;
    localparam int LIMIT = 4000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [31:0] cmd_addr;
    logic [2:0]  cmd_size;
    logic [7:0]  cmd_len;
    logic [1:0]  cmd_burst;
    logic        beat_valid;
    logic        beat_ready;
    logic [31:0] beat_addr;
    logic [3:0]  beat_strb;
    logic        beat_last;

    always #4 clk = ~clk;

    strb_burst_gen u_strb_burst_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_addr  (cmd_addr),
        .cmd_size  (cmd_size),
        .cmd_len   (cmd_len),
        .cmd_burst (cmd_burst),
        .beat_valid(beat_valid),
        .beat_ready(beat_ready),
        .beat_addr (beat_addr),
        .beat_strb (beat_strb),
        .beat_last (beat_last)
    );

    typedef struct {
        logic [31:0] a;
        logic [3:0]  s;
        logic        l;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    int unsigned ca[NCMD];
    int          cs[NCMD];
    int          cl[NCMD];
    int          cb[NCMD];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural beat list for one burst
    function automatic void plan_burst(int unsigned a0, int sz, int ln, int bt);
        int          nb;
        int unsigned a;
        int unsigned al;
        int unsigned wl;
        int unsigned base;
        int          lo;
        int          hi;
        exp_t        e;
        nb   = 1 << ((sz > 2) ? 2 : sz);
        wl   = (ln + 1) * nb;
        base = (a0 / wl) * wl;
        a    = a0;
        for (int b = 0; b <= ln; b++) begin
            al = a - (a % nb);
            lo = a % 4;
            hi = (al % 4) + nb;
            e.a = a;
            for (int k = 0; k < 4; k++) e.s[k] = (k >= lo) && (k < hi);
            e.l = (b == ln);
            if (b == 0)        e.tag = "R3";
            else if (bt == 0)  e.tag = "R5";
            else if (bt == 2)  e.tag = "R6";
            else if (bt == 3)  e.tag = "R9";
            else               e.tag = "R4";
            q.push_back(e);
            if (bt == 0)      a = a;
            else if (bt == 2) a = base + ((al + nb - base) % wl);
            else              a = al + nb;
        end
    endfunction

    initial begin
        int  ci;
        int  cyc;
        bit  stalled;
        bit  junk;
        exp_t e;
        // address, size, len, burst
        ca[0]  = 32'h100; cs[0]  = 2; cl[0]  = 3;  cb[0]  = 1; // aligned full width
        ca[1]  = 32'h200; cs[1]  = 0; cl[1]  = 5;  cb[1]  = 1; // byte rotation
        ca[2]  = 32'h300; cs[2]  = 1; cl[2]  = 3;  cb[2]  = 1; // lane pairs
        ca[3]  = 32'h402; cs[3]  = 2; cl[3]  = 2;  cb[3]  = 1; // clipped first beat
        ca[4]  = 32'h501; cs[4]  = 1; cl[4]  = 3;  cb[4]  = 1; // narrow and unaligned
        ca[5]  = 32'h600; cs[5]  = 2; cl[5]  = 3;  cb[5]  = 0; // fixed full
        ca[6]  = 32'h603; cs[6]  = 0; cl[6]  = 2;  cb[6]  = 0; // fixed single lane
        ca[7]  = 32'h708; cs[7]  = 2; cl[7]  = 3;  cb[7]  = 2; // wrap 4 x 4
        ca[8]  = 32'h806; cs[8]  = 1; cl[8]  = 7;  cb[8]  = 2; // wrap 8 x 2
        ca[9]  = 32'h90D; cs[9]  = 0; cl[9]  = 15; cb[9]  = 2; // wrap 16 x 1
        ca[10] = 32'hA00; cs[10] = 3; cl[10] = 1;  cb[10] = 1; // size clamp
        ca[11] = 32'hB01; cs[11] = 0; cl[11] = 2;  cb[11] = 3; // reserved code
        ca[12] = 32'hC00; cs[12] = 2; cl[12] = 0;  cb[12] = 1; // single beat
        ca[13] = 32'hD03; cs[13] = 2; cl[13] = 20; cb[13] = 1; // long unaligned
        ca[14] = 32'hE04; cs[14] = 1; cl[14] = 1;  cb[14] = 2; // wrap 2 x 2

        rst_n      = 1'b0;
        cmd_valid  = 1'b0;
        cmd_addr   = '0;
        cmd_size   = '0;
        cmd_len    = '0;
        cmd_burst  = '0;
        beat_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready in reset", 32'(cmd_ready), 32'd1);
        chk(beat_valid == 1'b0, "R1", "beat_valid in reset", 32'(beat_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready after reset", 32'(cmd_ready), 32'd1);
        chk(beat_valid == 1'b0, "R1", "beat_valid after reset", 32'(beat_valid), 32'd0);

        ci = 0; cyc = 0; stalled = 0; junk = 0;
        while ((ci < NCMD || q.size() > 0) && cyc < LIMIT) begin
            if (q.size() == 0) begin
                chk(beat_valid == 1'b0, "R8", "beat_valid when idle", 32'(beat_valid), 32'd0);
                chk(cmd_ready == 1'b1, "R8", "cmd_ready when idle", 32'(cmd_ready), 32'd1);
            end else begin
                e = q[0];
                if (stalled) e.tag = "R7";
                else if (junk && e.tag != "R3") e.tag = "R10";
                chk(beat_valid == 1'b1, e.tag, "beat_valid", 32'(beat_valid), 32'd1);
                chk(cmd_ready == 1'b0, "R3", "cmd_ready while busy", 32'(cmd_ready), 32'd0);
                chk(beat_addr == e.a, e.tag, "beat_addr", beat_addr, e.a);
                chk(beat_strb == e.s, "R2", "beat_strb", 32'(beat_strb), 32'(e.s));
                chk(beat_last == e.l, "R8", "beat_last", 32'(beat_last), 32'(e.l));
            end

            stalled = 1'b0;
            junk    = 1'b0;
            if (q.size() > 0) begin
                if (ci % 2 == 0) begin
                    // stalled consumer with a rival command held on the input (R10)
                    beat_ready = ((cyc % 4) != 2);
                    cmd_valid  = 1'b1;
                    cmd_addr   = 32'hFFF0_0000 + 32'(cyc);
                    cmd_size   = 3'd0;
                    cmd_len    = 8'd9;
                    cmd_burst  = 2'd0;
                    junk       = 1'b1;
                end else begin
                    beat_ready = 1'b1;
                    cmd_valid  = 1'b0;
                end
                stalled = !beat_ready;
                if (beat_ready) void'(q.pop_front());
            end else if (ci < NCMD) begin
                beat_ready = 1'b0;
                cmd_valid  = 1'b1;
                cmd_addr   = ca[ci];
                cmd_size   = 3'(cs[ci]);
                cmd_len    = 8'(cl[ci]);
                cmd_burst  = 2'(cb[ci]);
                plan_burst(ca[ci], cs[ci], cl[ci], cb[ci]);
                ci++;
            end else begin
                cmd_valid  = 1'b0;
                beat_ready = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end

        if (cyc >= LIMIT) begin
            chk(1'b0, "R8", "watchdog expired", 32'(cyc), 32'(LIMIT));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule